// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It reads translation descriptors from memory, one 32-bit word at a time. A walk first reads a context descriptor, located from a root pointer and a context number. It then follows table pointers through at most three levels of tables. It stops at the first page entry it finds, at an invalid entry or at a reserved entry. A page entry found at the first, second or third level maps a 16 MB, 256 KB or 4 KB page.

Two kinds of result are possible. A completed walk reports the physical address, a page-size code and the three permission bits of the final entry. A separate checker decodes those bits. A failed walk reports a fault code that records the depth reached and the kind of bad entry found. The final entry may still lack its accessed flag, or a write may find its modified flag clear. In either case the walker writes the entry back with the needed flags set before it reports completion. When translation is turned off, requests complete at once with the virtual address passed straight through.

Top module: `pt_walker`

## Requirements
- R1: When `cfg_enable` is low, an accepted request raises `done` with `bypass`=1 on the next cycle. In that result `paddr` is the virtual address zero-extended, `page_size` is 0 and `perm` is 0. `busy` stays low and no memory access is made.
- R2: The first read of a walk goes to `cfg_root_ptr`*16 + `cfg_ctx`*4.
- R3: Descriptor bits [1:0] give its type: 0 invalid, 1 table pointer, 2 page entry, 3 reserved. A table pointer found at depth d leads to a read at (descriptor with bits [1:0] cleared)*16 plus an index*4. The index is VA[31:24] after the context descriptor (d=0), VA[23:18] after a depth-1 descriptor, and VA[17:12] after a depth-2 descriptor.
- R4: A page entry at depth 1, 2 or 3 gives `page_size` 2, 1 or 0, with an offset of VA[23:0], VA[17:0] or VA[11:0]. `paddr` is (entry bits [31:8])*4096 plus that offset.
- R5: A walk that fails raises `fault` with `fault_code` = depth*256 + kind*4. Kind is 1 for an invalid entry and 4 for a reserved entry. A page entry found in the context descriptor is kind 4 at depth 0. `done` and `fault` are never high together.
- R6: A table pointer found at depth 3 is a fault of kind 4, so `fault_code` is 0x310.
- R7: Entry bit 5 is the accessed flag and bit 6 is the modified flag. The final entry is written back to the address it was read from when bit 5 is clear, or when the request is a write and bit 6 is clear. The written word is the entry with bit 5 set, and with bit 6 also set for writes. `done` follows the write acknowledge. No write is made when no flag needs setting.
- R8: `mem_req_valid` is a one-cycle pulse. No new request is issued until `mem_rsp_valid` has answered the previous one. Writes are also acknowledged through `mem_rsp_valid`.
- R9: `busy` rises the cycle after a translated request is accepted and falls in the cycle in which `done` or `fault` is raised. A `req_valid` seen while `busy` is high is ignored.
- R10: On `done`, `perm` equals bits [4:2] of the final entry. `acc_class` equals {ifetch, user, write} of the request.
- R11: After reset, `busy`, `done`, `fault` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Translation enable |
| cfg_root_ptr | input | 32 | Context table root pointer |
| cfg_ctx | input | CTX_W | Current context number |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_ifetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is from user mode |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 36 | Memory word address (byte units) |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | Translation completed pulse |
| fault | output | 1 | Translation failed pulse |
| fault_code | output | 10 | Depth and kind of failure |
| paddr | output | 36 | Physical address |
| page_size | output | 2 | 0: 4 KB, 1: 256 KB, 2: 16 MB |
| perm | output | 3 | Permission bits of the final entry |
| bypass | output | 1 | Result came from pass-through |
| acc_class | output | 3 | Echo of {ifetch, user, write} |

## Verification
The assertions check on every cycle that memory requests are single pulses, that a fall of `busy` always coincides with a result, and that `done` and `fault` never coincide. They also check that every fault code has the depth-and-kind shape, that a pass-through result made no memory access, and that every writeback word carries the accessed flag, plus the modified flag for writes. Only the bench scenarios can show that the addresses, offsets, page sizes and fault depths match a real table layout. They also show the number of reads per walk, whether a writeback happens at all, and that a request arriving during a walk has no effect.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PA_W    = 36;
  localparam int FC_W    = 10;
  localparam int ACC_BIT = 5;
  localparam int MOD_BIT = 6;

  typedef enum logic [1:0] {
    DT_INVALID = 2'd0,
    DT_TABLE   = 2'd1,
    DT_PAGE    = 2'd2,
    DT_RSVD    = 2'd3
  } dtype_e;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_256K = 2'd1;
  localparam logic [1:0] SZ_16M  = 2'd2;

  // address of the context descriptor
  function automatic logic [PA_W-1:0] root_addr(input logic [31:0] ptr, input logic [31:0] ctx);
    return {ptr, 4'b0000} + {2'b00, ctx, 2'b00};
  endfunction

  // address of the next descriptor, lvl = depth of the current table pointer
  function automatic logic [PA_W-1:0] table_addr(input logic [31:0] desc, input logic [31:0] va,
                                                 input logic [1:0] lvl);
    logic [7:0] idx;
    case (lvl)
      2'd0:    idx = va[31:24];
      2'd1:    idx = {2'b00, va[23:18]};
      default: idx = {2'b00, va[17:12]};
    endcase
    return {desc[31:2], 2'b00, 4'b0000} + {26'd0, idx, 2'b00};
  endfunction

  // physical address from a page entry found at depth lvl
  function automatic logic [PA_W-1:0] page_addr(input logic [31:0] desc, input logic [31:0] va,
                                                input logic [1:0] lvl);
    logic [23:0] off;
    case (lvl)
      2'd1:    off = va[23:0];
      2'd2:    off = {6'd0, va[17:0]};
      default: off = {12'd0, va[11:0]};
    endcase
    return {desc[31:8], 12'd0} + {12'd0, off};
  endfunction

  function automatic logic [1:0] size_of(input logic [1:0] lvl);
    case (lvl)
      2'd1:    return SZ_16M;
      2'd2:    return SZ_256K;
      default: return SZ_4K;
    endcase
  endfunction

  function automatic logic [FC_W-1:0] fault_code(input logic [1:0] lvl, input dtype_e t);
    logic [2:0] kind;
    kind = (t == DT_INVALID) ? 3'd1 : 3'd4;
    return {lvl, 3'b000, kind, 2'b00};
  endfunction
endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
  import ptw_pkg::*;
(
  input  logic [31:0]      desc,
  input  logic [31:0]      va,
  input  logic [1:0]       lvl,
  input  logic             is_write,
  output logic             is_table,
  output logic             is_page,
  output logic             is_fault,
  output logic [PA_W-1:0]  next_addr,
  output logic [PA_W-1:0]  phys,
  output logic [1:0]       size,
  output logic [2:0]       perm,
  output logic [FC_W-1:0]  code,
  output logic             need_wb,
  output logic [31:0]      wb_word
);
  dtype_e t;
  logic [31:0] set_bits;

  always_comb begin
    t         = dtype_e'(desc[1:0]);
    is_table  = (t == DT_TABLE) && (lvl != 2'd3);
    is_page   = (t == DT_PAGE) && (lvl != 2'd0);
    is_fault  = !is_table && !is_page;
    next_addr = table_addr(desc, va, lvl);
    phys      = page_addr(desc, va, lvl);
    size      = size_of(lvl);
    perm      = desc[4:2];
    code      = fault_code(lvl, t);
    need_wb   = is_page && (!desc[ACC_BIT] || (is_write && !desc[MOD_BIT]));
    set_bits  = 32'd1 << ACC_BIT;
    if (is_write) set_bits = set_bits | (32'd1 << MOD_BIT);
    wb_word   = desc | set_bits;
  end
endmodule

// File: rtl/ptw_result_reg.sv
module ptw_result_reg
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_done,
  input  logic             ld_fault,
  input  logic             ld_bypass,
  input  logic [PA_W-1:0]  paddr_in,
  input  logic [1:0]       size_in,
  input  logic [2:0]       perm_in,
  input  logic [FC_W-1:0]  code_in,
  input  logic [2:0]       acc_in,
  output logic             done,
  output logic             fault,
  output logic             bypass,
  output logic [PA_W-1:0]  paddr,
  output logic [1:0]       page_size,
  output logic [2:0]       perm,
  output logic [FC_W-1:0]  fault_code,
  output logic [2:0]       acc_class
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fault      <= 1'b0;
      bypass     <= 1'b0;
      paddr      <= '0;
      page_size  <= '0;
      perm       <= '0;
      fault_code <= '0;
      acc_class  <= '0;
    end else begin
      done  <= ld_done;
      fault <= ld_fault;
      if (ld_done) begin
        bypass    <= ld_bypass;
        paddr     <= paddr_in;
        page_size <= size_in;
        perm      <= perm_in;
        acc_class <= acc_in;
      end
      if (ld_fault) begin
        bypass     <= 1'b0;
        fault_code <= code_in;
        acc_class  <= acc_in;
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [31:0]      cfg_root_ptr,
  input  logic [CTX_W-1:0] cfg_ctx,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic             req_write,
  input  logic             req_ifetch,
  input  logic             req_user,
  output logic             busy,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  output logic [35:0]      mem_req_addr,
  output logic [31:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_rdata,
  output logic             done,
  output logic             fault,
  output logic [9:0]       fault_code,
  output logic [35:0]      paddr,
  output logic [1:0]       page_size,
  output logic [2:0]       perm,
  output logic             bypass,
  output logic [2:0]       acc_class
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDW, S_WR, S_WRW} st_e;

  st_e              st;
  logic [1:0]       lvl_q;
  logic [31:0]      va_q;
  logic [2:0]       acc_q;
  logic [PA_W-1:0]  maddr_q;
  logic [31:0]      wdata_q;
  logic [PA_W-1:0]  pa_q;
  logic [1:0]       sz_q;
  logic [2:0]       perm_q;

  // named internal events
  logic accept, start_walk, start_bypass, rsp_here;
  logic walk_step, walk_fault, walk_hit, walk_wb, wb_ack;

  logic             d_table, d_page, d_fault, d_wb;
  logic [PA_W-1:0]  d_next, d_phys;
  logic [1:0]       d_size;
  logic [2:0]       d_perm;
  logic [FC_W-1:0]  d_code;
  logic [31:0]      d_wbw;

  ptw_desc_decode u_dec (
    .desc(mem_rsp_rdata), .va(va_q), .lvl(lvl_q), .is_write(acc_q[0]),
    .is_table(d_table), .is_page(d_page), .is_fault(d_fault),
    .next_addr(d_next), .phys(d_phys), .size(d_size), .perm(d_perm),
    .code(d_code), .need_wb(d_wb), .wb_word(d_wbw)
  );

  assign accept       = req_valid && (st == S_IDLE);
  assign start_walk   = accept && cfg_enable;
  assign start_bypass = accept && !cfg_enable;
  assign rsp_here     = (st == S_RDW) && mem_rsp_valid;
  assign walk_step    = rsp_here && d_table;
  assign walk_fault   = rsp_here && d_fault;
  assign walk_hit     = rsp_here && d_page && !d_wb;
  assign walk_wb      = rsp_here && d_page && d_wb;
  assign wb_ack       = (st == S_WRW) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      acc_q   <= '0;
      maddr_q <= '0;
      wdata_q <= '0;
      pa_q    <= '0;
      sz_q    <= '0;
      perm_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_walk) begin
          st      <= S_RD;
          lvl_q   <= 2'd0;
          va_q    <= req_vaddr;
          acc_q   <= {req_ifetch, req_user, req_write};
          maddr_q <= root_addr(cfg_root_ptr, 32'(cfg_ctx));
        end
        S_RD:   st <= S_RDW;
        S_RDW: begin
          if (walk_step) begin
            st      <= S_RD;
            lvl_q   <= lvl_q + 2'd1;
            maddr_q <= d_next;
          end else if (walk_wb) begin
            st      <= S_WR;
            wdata_q <= d_wbw;
            pa_q    <= d_phys;
            sz_q    <= d_size;
            perm_q  <= d_perm;
          end else if (rsp_here) begin
            st <= S_IDLE;
          end
        end
        S_WR:   st <= S_WRW;
        S_WRW:  if (wb_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_RD) || (st == S_WR);
  assign mem_req_write = (st == S_WR);
  assign mem_req_addr  = maddr_q;
  assign mem_req_wdata = wdata_q;

  logic [PA_W-1:0] res_pa;
  logic [1:0]      res_sz;
  logic [2:0]      res_perm;
  logic [2:0]      res_acc;

  always_comb begin
    res_pa   = pa_q;
    res_sz   = sz_q;
    res_perm = perm_q;
    res_acc  = acc_q;
    if (start_bypass) begin
      res_pa   = {4'd0, req_vaddr};
      res_sz   = SZ_4K;
      res_perm = 3'd0;
      res_acc  = {req_ifetch, req_user, req_write};
    end else if (walk_hit) begin
      res_pa   = d_phys;
      res_sz   = d_size;
      res_perm = d_perm;
    end
  end

  ptw_result_reg u_res (
    .clk(clk), .rst_n(rst_n),
    .ld_done(walk_hit || wb_ack || start_bypass), .ld_fault(walk_fault),
    .ld_bypass(start_bypass), .paddr_in(res_pa), .size_in(res_sz),
    .perm_in(res_perm), .code_in(d_code), .acc_in(res_acc),
    .done(done), .fault(fault), .bypass(bypass), .paddr(paddr),
    .page_size(page_size), .perm(perm), .fault_code(fault_code), .acc_class(acc_class)
  );

  // assertions
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_busy_ends_with_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fault));

  p_done_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_code_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_code[1:0] == 2'b00) && (fault_code[7:5] == 3'b000) &&
              ((fault_code[4:2] == 3'd1) || (fault_code[4:2] == 3'd4)));

  p_bypass_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bypass) |-> (!$past(mem_req_valid) && !$past(busy)));

  p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[ACC_BIT]);

  p_wb_modified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && acc_q[0]) |-> mem_req_wdata[MOD_BIT]);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1;
  logic [31:0] cfg_root_ptr = 32'h0000_0100;
  logic [7:0]  cfg_ctx = 8'd3;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0, req_ifetch = 1'b0, req_user = 1'b0;
  logic        busy, mem_req_valid, mem_req_write;
  logic [35:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        done, fault, bypass;
  logic [9:0]  fault_code;
  logic [35:0] paddr;
  logic [1:0]  page_size;
  logic [2:0]  perm, acc_class;

  always #5ns clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_root_ptr(cfg_root_ptr),
    .cfg_ctx(cfg_ctx), .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_ifetch(req_ifetch), .req_user(req_user), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata), .done(done), .fault(fault),
    .fault_code(fault_code), .paddr(paddr), .page_size(page_size), .perm(perm),
    .bypass(bypass), .acc_class(acc_class)
  );

  // memory model: two-cycle response latency
  logic [31:0] mem_q [logic [35:0]];
  logic [35:0] rd_log [$];
  int n_rd = 0, n_wr = 0, n_overlap = 0;
  logic        p1_v = 1'b0, p1_w = 1'b0, pending = 1'b0;
  logic [35:0] p1_a = '0;
  logic [31:0] p1_d = '0;

  function automatic logic [31:0] rd(input logic [35:0] a);
    return mem_q.exists(a) ? mem_q[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      p1_v = 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_rdata <= '0; pending = 1'b0;
    end else begin
      mem_rsp_valid <= p1_v;
      if (p1_v) begin
        if (p1_w) mem_q[p1_a] = p1_d;
        else mem_rsp_rdata <= rd(p1_a);
      end
      if (p1_v) pending = 1'b0;
      if (mem_req_valid) begin
        if (pending) n_overlap++;
        pending = 1'b1;
        if (mem_req_write) n_wr++; else begin n_rd++; rd_log.push_back(mem_req_addr); end
      end
      p1_v = mem_req_valid; p1_w = mem_req_write; p1_a = mem_req_addr; p1_d = mem_req_wdata;
    end
  end

  int n_checks = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model of a walk over the bench memory
  logic        e_f, e_wb;
  logic [9:0]  e_code;
  logic [35:0] e_pa, e_wba;
  logic [1:0]  e_sz;
  logic [2:0]  e_pm;
  logic [31:0] e_wbd;
  int          e_rd;

  task automatic ref_walk(input logic [31:0] va, input bit wr);
    longint a, d, t, idx, obits;
    a = longint'(cfg_root_ptr) * 16 + longint'(cfg_ctx) * 4;
    e_rd = 0; e_wb = 0; e_f = 1; e_code = 0; e_pa = 0; e_sz = 0; e_pm = 0; e_wba = 0; e_wbd = 0;
    for (int lv = 0; lv < 4; lv++) begin
      d = longint'(rd(a[35:0])); t = d % 4; e_rd++;
      if (t == 1 && lv < 3) begin
        idx = (lv == 0) ? (longint'(va) >> 24) : (lv == 1) ? ((longint'(va) >> 18) % 64)
                                                          : ((longint'(va) >> 12) % 64);
        a = (d - t) * 16 + idx * 4;
      end else if (t == 2 && lv > 0) begin
        obits = (lv == 1) ? 24 : (lv == 2) ? 18 : 12;
        e_f  = 0;
        e_pa = 36'((d >> 8) * 4096 + (longint'(va) % (64'sd1 <<< obits)));
        e_sz = 2'(3 - lv);
        e_pm = 3'((d >> 2) % 8);
        e_wb = (((d >> 5) % 2) == 0) || (wr && (((d >> 6) % 2) == 0));
        e_wba = a[35:0];
        e_wbd = 32'(d) | 32'h20 | (wr ? 32'h40 : 32'h0);
        return;
      end else begin
        e_code = 10'(lv * 256 + ((t == 0) ? 4 : 16));
        return;
      end
    end
  endtask

  bit got_done, got_fault;

  task automatic walk(input logic [31:0] va, input bit wr, input bit usr, input bit ifc);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; req_ifetch = ifc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    got_done = done; got_fault = fault;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr, usr, ifc;
    logic [31:0] e1, e2, e3;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h1234_5678, 1'b0, 1'b0, 1'b0, 32'h00AB_CD2E, 32'h0,         32'h0},
    '{32'h8765_4321, 1'b1, 1'b1, 1'b0, 32'h0000_0301, 32'h0055_5076, 32'h0},
    '{32'hCAFE_B123, 1'b0, 1'b0, 1'b1, 32'h0000_0301, 32'h0000_0401, 32'h0001_2306},
    '{32'h0040_7ABC, 1'b1, 1'b1, 1'b0, 32'h0000_0301, 32'h0000_0401, 32'h0009_8722},
    '{32'h0040_7ABC, 1'b1, 1'b0, 1'b0, 32'h0000_0301, 32'h0000_0401, 32'h0009_8762},
    '{32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 32'h0000_0301, 32'h0000_0401, 32'h00FF_FF2A},
    '{32'h0100_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0,         32'h0},
    '{32'h0200_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0003, 32'h0,         32'h0},
    '{32'h0304_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0301, 32'h0000_0000, 32'h0},
    '{32'h0308_0000, 1'b1, 1'b0, 1'b0, 32'h0000_0301, 32'h0000_0003, 32'h0},
    '{32'h0400_3000, 1'b0, 1'b0, 1'b0, 32'h0000_0301, 32'h0000_0401, 32'h0000_0000},
    '{32'h0400_5000, 1'b0, 1'b0, 1'b0, 32'h0000_0301, 32'h0000_0401, 32'h0000_0401},
    '{32'h0400_6000, 1'b0, 1'b0, 1'b0, 32'h0000_0301, 32'h0000_0401, 32'h0000_0007},
    '{32'h05AB_CDEF, 1'b1, 1'b0, 1'b0, 32'h0077_7002, 32'h0,         32'h0}
  };

  task automatic load(input vec_t v);
    mem_q.delete();
    mem_q[36'h100C] = 32'h0000_0201;
    mem_q[36'h2000 + {26'd0, v.va[31:24], 2'b00}] = v.e1;
    mem_q[36'h3000 + {28'd0, v.va[23:18], 2'b00}] = v.e2;
    mem_q[36'h4000 + {28'd0, v.va[17:12], 2'b00}] = v.e3;
  endtask

  task automatic compare(input string tag, input vec_t v);
    if (e_f) begin
      chk({tag, " R5 fault raised"}, {62'd0, got_fault, got_done}, 64'd2);
      chk({tag, " R5 R6 fault_code"}, 64'(fault_code), 64'(e_code));
    end else begin
      chk({tag, " R4 done raised"}, {62'd0, got_fault, got_done}, 64'd1);
      chk({tag, " R4 paddr"}, 64'(paddr), 64'(e_pa));
      chk({tag, " R4 page_size"}, 64'(page_size), 64'(e_sz));
      chk({tag, " R10 perm"}, 64'(perm), 64'(e_pm));
      chk({tag, " R10 acc_class"}, 64'(acc_class), 64'({v.ifc, v.usr, v.wr}));
      if (e_wb) chk({tag, " R7 writeback word"}, 64'(rd(e_wba)), 64'(e_wbd));
    end
  endtask

  int rd0, wr0;

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy after reset", 64'(busy), 64'd0);
    chk("R11 done/fault after reset", 64'({done, fault}), 64'd0);
    chk("R11 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R2 R3 R4 R5 R6 R7 R10
    for (int k = 0; k < NV; k++) begin
      load(VEC[k]);
      ref_walk(VEC[k].va, VEC[k].wr);
      rd0 = n_rd; wr0 = n_wr;
      rd_log.delete();
      walk(VEC[k].va, VEC[k].wr, VEC[k].usr, VEC[k].ifc);
      compare($sformatf("vec%0d", k), VEC[k]);
      chk($sformatf("vec%0d R3 read count", k), 64'(n_rd - rd0), 64'(e_rd));
      chk($sformatf("vec%0d R7 write count", k), 64'(n_wr - wr0), 64'(e_wb));
      chk($sformatf("vec%0d R2 first read address", k), 64'(rd_log[0]), 64'h100C);
      @(negedge clk);
      chk($sformatf("vec%0d R9 pulse ends, busy low", k), 64'({done, fault, busy}), 64'd0);
    end
    chk("R8 no overlapping memory requests", 64'(n_overlap), 64'd0);

    // R1 pass-through
    cfg_enable = 1'b0;
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    req_vaddr = 32'hDEAD_BEEF; req_write = 1'b1; req_user = 1'b1; req_ifetch = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 bypass done next cycle", 64'({done, bypass, busy}), 64'b110);
    chk("R1 bypass paddr", 64'(paddr), 64'h0_DEAD_BEEF);
    chk("R1 bypass page_size and perm", 64'({page_size, perm}), 64'd0);
    chk("R1 bypass acc_class", 64'(acc_class), 64'b011);
    repeat (4) @(negedge clk);
    chk("R1 bypass memory untouched", 64'(n_rd - rd0 + n_wr - wr0), 64'd0);
    cfg_enable = 1'b1;

    // R5 context descriptor invalid and page at depth 0
    load(VEC[0]);
    mem_q[36'h100C] = 32'h0;
    walk(32'h1234_5678, 1'b0, 1'b0, 1'b0);
    chk("R5 context invalid fault", 64'({got_fault, fault_code}), 64'({1'b1, 10'h004}));
    mem_q[36'h100C] = 32'h0000_0202;
    walk(32'h1234_5678, 1'b0, 1'b0, 1'b0);
    chk("R5 context page fault", 64'({got_fault, fault_code}), 64'({1'b1, 10'h010}));

    // R2 different root and context
    cfg_root_ptr = 32'h0000_0200; cfg_ctx = 8'd5;
    mem_q.delete(); rd_log.delete();
    mem_q[36'h2014] = 32'h0;
    walk(32'h0, 1'b0, 1'b0, 1'b0);
    chk("R2 first read address alt", 64'(rd_log[0]), 64'h2014);
    cfg_root_ptr = 32'h0000_0100; cfg_ctx = 8'd3;

    // R9 request during a walk is ignored
    load(VEC[2]);
    ref_walk(VEC[2].va, 1'b0);
    rd0 = n_rd;
    @(negedge clk);
    req_vaddr = VEC[2].va; req_write = 1'b0; req_user = 1'b0; req_ifetch = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", 64'(busy), 64'd1);
    @(negedge clk); @(negedge clk);
    req_vaddr = 32'h0100_0000; req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    chk("R9 original walk result", 64'({done, paddr}), 64'({1'b1, e_pa}));
    chk("R9 acc_class from first request", 64'(acc_class), 64'b100);
    repeat (6) @(negedge clk);
    chk("R9 no second walk", 64'(n_rd - rd0), 64'(e_rd));

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule